// File: doc/BRIEF.md
# Accumulator CPU Instruction Sequencer

This block is the control unit of a small 8-bit accumulator processor. It captures the byte that instruction memory presents at the program counter into an instruction register, decodes it, and drives the datapath: which register or memory drives the central bus, which register takes the bus value, the ALU operation and its write enable, the memory read and write strobes, and a program counter advance enable. The register file, the ALU with its flags, and the memory lie outside the block; the memory address for load, store and taken branches always comes from register 6, so the block has no address output.

Each instruction takes a fetch cycle and an execute cycle. Load and conditional branch take one extra cycle, and a halt instruction parks the unit until reset. The sequencer has five named states. `ST_FETCH` latches the instruction and always goes to `ST_EXEC`. `ST_EXEC` goes to `ST_LOAD_X` for a load, to `ST_BR_X` for a branch, to `ST_HALT` for halt, and back to `ST_FETCH` otherwise. `ST_LOAD_X` and `ST_BR_X` always return to `ST_FETCH`. `ST_HALT` stays where it is. A one-bit register records the branch condition at the end of `ST_EXEC`.

Instruction layout. If bit 7 is 1, the instruction is an ALU op: bits 6:3 are the operation and bits 2:0 are the operand register. If bits 7:6 are `01`, it is a move: bits 5:3 are the destination and bits 2:0 are the source. If bits 7:6 are `00`, bits 5:3 give the opcode: 0 is load, 1 is store (source register in bits 2:0), 2 is branch if zero, 3 is branch if carry, 4 is branch if negative, 7 is halt, and 5 and 6 are no-ops. The bus source code is four bits wide: values 0 to 7 select a register and value 8 selects memory read data. Register 7 is the program counter.

Top module: `cu8_ctrl`

## Requirements
- R1: While reset is low, the state is fetch: `ir_load_o` is 1, `ir_o` is 0, and every other output is 0.
- R2: In a fetch cycle, `ir_load_o` is 1 and every other output is 0. At the following edge `ir_o` takes `rom_data_i`, and it holds that value until the next fetch cycle.
- R3: An ALU instruction (bit 7 = 1) executes in one cycle with `alu_we_o`=1, `alu_op_o`=bits 6:3, `bus_src_o`={0,bits 2:0} and `pc_inc_o`=1.
- R4: A move (bits 7:6 = 01) executes in one cycle with `bus_src_o`={0,bits 2:0}, `bus_dst_o`=bits 5:3 and `dst_we_o`=1. `pc_inc_o` is 1 unless the destination is 7, in which case it is 0.
- R5: A load (bits 7:3 = 00000) asserts only `mem_rd_o` in its execute cycle, with `pc_inc_o`=0. In the next cycle it drives `bus_src_o`=8, `bus_dst_o`=0, `dst_we_o`=1 and `pc_inc_o`=1.
- R6: A store (bits 7:3 = 00001) executes in one cycle with `mem_wr_o`=1, `bus_src_o`={0,bits 2:0} and `pc_inc_o`=1.
- R7: A branch (bits 7:6 = 00, opcode 2, 3 or 4, testing zero, carry or negative respectively) drives all outputs to 0 in its execute cycle. In the extension cycle, if the tested flag was 1 it drives `bus_src_o`=6, `bus_dst_o`=7, `dst_we_o`=1 and `pc_inc_o`=0; otherwise only `pc_inc_o` is 1.
- R8: A branch decision uses the flags as they were during the execute cycle. Flag changes during the extension cycle have no effect on the outputs.
- R9: After a halt (bits 7:6 = 00, opcode 7) executes, every output including `ir_load_o` stays 0 and `ir_o` is unchanged until reset, whatever `rom_data_i` does.
- R10: Opcodes 5 and 6 (bits 7:6 = 00) execute in one cycle with only `pc_inc_o`=1.
- R11: At most one of `mem_rd_o`, `mem_wr_o`, `alu_we_o` and `dst_we_o` is 1 in any cycle. Every select output that the cycle does not use is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rom_data_i | input | 8 | Instruction byte at the current program counter |
| flag_z_i | input | 1 | Zero flag from the ALU |
| flag_c_i | input | 1 | Carry flag from the ALU |
| flag_n_i | input | 1 | Negative flag from the ALU |
| ir_o | output | 8 | Current instruction register |
| ir_load_o | output | 1 | Fetch cycle: instruction register loads this edge |
| bus_src_o | output | 4 | Bus driver: register 0..7, or 8 for memory data |
| bus_dst_o | output | 3 | Register written from the bus |
| dst_we_o | output | 1 | Write enable for the `bus_dst_o` register |
| alu_op_o | output | 4 | ALU operation code |
| alu_we_o | output | 1 | Accumulator takes the ALU result |
| mem_rd_o | output | 1 | Memory read at the register 6 address |
| mem_wr_o | output | 1 | Memory write of the bus value at the register 6 address |
| pc_inc_o | output | 1 | Program counter advances at this edge |

## Verification
An instruction placed on `rom_data_i` during a fetch cycle appears on `ir_o`, together with its execute controls, one clock edge later. Controls for the load or branch extension cycle come one edge after that, and the next fetch cycle follows one edge after the last execute or extension cycle. The bench sweeps all 256 instruction bytes, and sweeps all eight flag combinations for each branch byte. It advances one edge at a time and compares the whole output vector at the falling edge after each rising edge. This means each result is checked in exactly the cycle it is due, and the next fetch is checked too. Between those edges the bench inverts the flags during branch extension cycles and changes `rom_data_i` outside fetch cycles, and it holds a halted unit for several cycles before resetting it.

// File: rtl/cu8_pkg.sv
package cu8_pkg;
    localparam int CU_IW    = 8;
    localparam int CU_RW    = 3;
    localparam int CU_OPW   = CU_IW - 1 - CU_RW;
    localparam int CU_SRCW  = CU_RW + 1;
    localparam int CU_CODEW = CU_IW - 2 - CU_RW;

    localparam logic [CU_SRCW-1:0] SRC_MEM  = CU_SRCW'(1 << CU_RW);
    localparam logic [CU_RW-1:0]   REG_ACC  = CU_RW'(0);
    localparam logic [CU_RW-1:0]   REG_ADDR = CU_RW'(6);
    localparam logic [CU_RW-1:0]   REG_PC   = CU_RW'(7);

    localparam logic [CU_CODEW-1:0] OPC_LOAD  = 3'd0;
    localparam logic [CU_CODEW-1:0] OPC_STORE = 3'd1;
    localparam logic [CU_CODEW-1:0] OPC_BZ    = 3'd2;
    localparam logic [CU_CODEW-1:0] OPC_BC    = 3'd3;
    localparam logic [CU_CODEW-1:0] OPC_BN    = 3'd4;
    localparam logic [CU_CODEW-1:0] OPC_HALT  = 3'd7;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_EXEC,
        ST_LOAD_X,
        ST_BR_X,
        ST_HALT
    } cu_state_t;

    typedef enum logic [2:0] {
        K_ALU,
        K_MOVE,
        K_LOAD,
        K_STORE,
        K_BRANCH,
        K_HALT,
        K_NOP
    } cu_kind_t;
endpackage

// File: rtl/cu8_decode.sv
module cu8_decode
    import cu8_pkg::*;
(
    input  logic [CU_IW-1:CU_RW] op_i,
    input  logic                 flag_z_i,
    input  logic                 flag_c_i,
    input  logic                 flag_n_i,
    output cu_kind_t             kind_o,
    output logic                 cond_o
);
    logic [CU_CODEW-1:0] code;
    assign code = op_i[CU_RW+CU_CODEW-1:CU_RW];

    always_comb begin
        if (op_i[CU_IW-1]) begin
            kind_o = K_ALU;
        end else if (op_i[CU_IW-2]) begin
            kind_o = K_MOVE;
        end else begin
            unique case (code)
                OPC_LOAD:              kind_o = K_LOAD;
                OPC_STORE:             kind_o = K_STORE;
                OPC_BZ, OPC_BC, OPC_BN: kind_o = K_BRANCH;
                OPC_HALT:              kind_o = K_HALT;
                default:               kind_o = K_NOP;
            endcase
        end
    end

    always_comb begin
        unique case (code)
            OPC_BZ:  cond_o = flag_z_i;
            OPC_BC:  cond_o = flag_c_i;
            OPC_BN:  cond_o = flag_n_i;
            default: cond_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cu8_seq.sv
module cu8_seq
    import cu8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CU_IW-1:0] rom_data_i,
    input  cu_kind_t         kind_i,
    input  logic             cond_i,
    output cu_state_t        state_o,
    output logic [CU_IW-1:0] ir_o,
    output logic             taken_o
);
    cu_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: state_d = ST_EXEC;
            ST_EXEC: begin
                unique case (kind_i)
                    K_LOAD:   state_d = ST_LOAD_X;
                    K_BRANCH: state_d = ST_BR_X;
                    K_HALT:   state_d = ST_HALT;
                    default:  state_d = ST_FETCH;
                endcase
            end
            ST_LOAD_X: state_d = ST_FETCH;
            ST_BR_X:   state_d = ST_FETCH;
            ST_HALT:   state_d = ST_HALT;
            default:   state_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            ir_o    <= '0;
            taken_o <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FETCH) ir_o <= rom_data_i;
            if (state_q == ST_EXEC)  taken_o <= cond_i;
        end
    end

    assign state_o = state_q;

    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |=> (state_q == ST_HALT));
    a_r2_ir_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_FETCH) |=> $stable(ir_o));
    a_r5_load_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && kind_i == K_LOAD) |=> (state_q == ST_LOAD_X));
endmodule

// File: rtl/cu8_outgen.sv
module cu8_outgen
    import cu8_pkg::*;
(
    input  cu_state_t          state_i,
    input  cu_kind_t           kind_i,
    input  logic [CU_IW-1:0]   ir_i,
    input  logic               taken_i,
    output logic               ir_load_o,
    output logic [CU_SRCW-1:0] bus_src_o,
    output logic [CU_RW-1:0]   bus_dst_o,
    output logic               dst_we_o,
    output logic [CU_OPW-1:0]  alu_op_o,
    output logic               alu_we_o,
    output logic               mem_rd_o,
    output logic               mem_wr_o,
    output logic               pc_inc_o
);
    logic [CU_RW-1:0] f_lo, f_hi;
    assign f_lo = ir_i[CU_RW-1:0];
    assign f_hi = ir_i[2*CU_RW-1:CU_RW];

    always_comb begin
        ir_load_o = 1'b0;
        bus_src_o = '0;
        bus_dst_o = '0;
        dst_we_o  = 1'b0;
        alu_op_o  = '0;
        alu_we_o  = 1'b0;
        mem_rd_o  = 1'b0;
        mem_wr_o  = 1'b0;
        pc_inc_o  = 1'b0;
        unique case (state_i)
            ST_FETCH: ir_load_o = 1'b1;
            ST_EXEC: begin
                unique case (kind_i)
                    K_ALU: begin
                        alu_op_o  = ir_i[CU_IW-2:CU_RW];
                        bus_src_o = {1'b0, f_lo};
                        alu_we_o  = 1'b1;
                        pc_inc_o  = 1'b1;
                    end
                    K_MOVE: begin
                        bus_src_o = {1'b0, f_lo};
                        bus_dst_o = f_hi;
                        dst_we_o  = 1'b1;
                        pc_inc_o  = (f_hi != REG_PC);
                    end
                    K_LOAD:  mem_rd_o = 1'b1;
                    K_STORE: begin
                        bus_src_o = {1'b0, f_lo};
                        mem_wr_o  = 1'b1;
                        pc_inc_o  = 1'b1;
                    end
                    K_NOP:   pc_inc_o = 1'b1;
                    default: pc_inc_o = 1'b0;
                endcase
            end
            ST_LOAD_X: begin
                bus_src_o = SRC_MEM;
                bus_dst_o = REG_ACC;
                dst_we_o  = 1'b1;
                pc_inc_o  = 1'b1;
            end
            ST_BR_X: begin
                if (taken_i) begin
                    bus_src_o = {1'b0, REG_ADDR};
                    bus_dst_o = REG_PC;
                    dst_we_o  = 1'b1;
                end else begin
                    pc_inc_o  = 1'b1;
                end
            end
            default: pc_inc_o = 1'b0;
        endcase
    end

    always_comb begin
        a_r11_one_strobe: assert ($onehot0({mem_rd_o, mem_wr_o, alu_we_o, dst_we_o}));
    end
endmodule

// File: rtl/cu8_ctrl.sv
module cu8_ctrl
    import cu8_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CU_IW-1:0]   rom_data_i,
    input  logic               flag_z_i,
    input  logic               flag_c_i,
    input  logic               flag_n_i,
    output logic [CU_IW-1:0]   ir_o,
    output logic               ir_load_o,
    output logic [CU_SRCW-1:0] bus_src_o,
    output logic [CU_RW-1:0]   bus_dst_o,
    output logic               dst_we_o,
    output logic [CU_OPW-1:0]  alu_op_o,
    output logic               alu_we_o,
    output logic               mem_rd_o,
    output logic               mem_wr_o,
    output logic               pc_inc_o
);
    cu_state_t state;
    cu_kind_t  kind;
    logic      cond, taken;

    cu8_decode u_dec (
        .op_i     (ir_o[CU_IW-1:CU_RW]),
        .flag_z_i (flag_z_i),
        .flag_c_i (flag_c_i),
        .flag_n_i (flag_n_i),
        .kind_o   (kind),
        .cond_o   (cond)
    );

    cu8_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rom_data_i (rom_data_i),
        .kind_i     (kind),
        .cond_i     (cond),
        .state_o    (state),
        .ir_o       (ir_o),
        .taken_o    (taken)
    );

    cu8_outgen u_out (
        .state_i   (state),
        .kind_i    (kind),
        .ir_i      (ir_o),
        .taken_i   (taken),
        .ir_load_o (ir_load_o),
        .bus_src_o (bus_src_o),
        .bus_dst_o (bus_dst_o),
        .dst_we_o  (dst_we_o),
        .alu_op_o  (alu_op_o),
        .alu_we_o  (alu_we_o),
        .mem_rd_o  (mem_rd_o),
        .mem_wr_o  (mem_wr_o),
        .pc_inc_o  (pc_inc_o)
    );

    a_r2_fetch_latch: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load_o |=> (ir_o == $past(rom_data_i)));
    a_r2_fetch_once: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load_o |=> !ir_load_o);
    a_r5_load_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> (dst_we_o && bus_src_o == SRC_MEM && bus_dst_o == REG_ACC && pc_inc_o));
    a_r7_jump_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we_o && bus_dst_o == REG_PC) |-> !pc_inc_o);
endmodule

// File: tb/cu8_ctrl_test.sv
module cu8_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rom_data = 8'h00;
    logic       fz = 1'b0, fc = 1'b0, fn = 1'b0;
    logic [7:0] ir;
    logic       ir_load, dst_we, alu_we, mem_rd, mem_wr, pc_inc;
    logic [3:0] bus_src, alu_op;
    logic [2:0] bus_dst;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cu8_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rom_data_i(rom_data),
        .flag_z_i(fz), .flag_c_i(fc), .flag_n_i(fn),
        .ir_o(ir), .ir_load_o(ir_load), .bus_src_o(bus_src), .bus_dst_o(bus_dst),
        .dst_we_o(dst_we), .alu_op_o(alu_op), .alu_we_o(alu_we),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .pc_inc_o(pc_inc)
    );

    // {alu_we, alu_op, bus_src, bus_dst, dst_we, mem_rd, mem_wr, pc_inc, ir_load}
    function automatic logic [16:0] pk(input logic aw, input logic [3:0] op, input logic [3:0] src,
                                       input logic [2:0] dst, input logic we, input logic rd,
                                       input logic wr, input logic pc, input logic il);
        return {aw, op, src, dst, we, rd, wr, pc, il};
    endfunction

    function automatic logic [16:0] act_vec();
        return {alu_we, alu_op, bus_src, bus_dst, dst_we, mem_rd, mem_wr, pc_inc, ir_load};
    endfunction

    function automatic logic [16:0] exp_exec(input logic [7:0] b);
        if (b[7]) return pk(1'b1, b[6:3], {1'b0, b[2:0]}, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        if (b[6]) return pk(1'b0, 4'd0, {1'b0, b[2:0]}, b[5:3], 1'b1, 1'b0, 1'b0, (b[5:3] != 3'd7), 1'b0);
        case (b[5:3])
            3'd0:                 return pk(1'b0, 4'd0, 4'd0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
            3'd1:                 return pk(1'b0, 4'd0, {1'b0, b[2:0]}, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
            3'd5, 3'd6:           return pk(1'b0, 4'd0, 4'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            default:              return '0;
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] b);
        if (b[7]) return "R3";
        if (b[6]) return "R4";
        case (b[5:3])
            3'd0: return "R5";
            3'd1: return "R6";
            3'd7: return "R9";
            3'd5, 3'd6: return "R10";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %05h expected %05h", req, act, exp);
        end
    endtask

    task automatic chk_ir(input string req, input logic [7:0] exp);
        checks++;
        if (ir !== exp) begin
            errors++;
            $display("FAIL %s: ir got %02h expected %02h", req, ir, exp);
        end
    endtask

    task automatic chk_r11();
        checks++;
        if ((mem_rd + mem_wr + alu_we + dst_we) > 1) begin
            errors++;
            $display("FAIL R11: strobes got %b expected at most one", {mem_rd, mem_wr, alu_we, dst_we});
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1", act_vec(), pk(1'b0, 4'd0, 4'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
        chk_ir("R1", 8'h00);
        rst_n = 1'b1;
    endtask

    // Entered at a falling edge during a fetch cycle.
    task automatic run(input logic [7:0] b, input logic [2:0] f);
        logic tk;
        chk("R2", act_vec(), pk(1'b0, 4'd0, 4'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
        rom_data = b;
        {fn, fc, fz} = f;
        @(posedge clk); @(negedge clk);
        chk_ir("R2", b);
        chk(req_of(b), act_vec(), exp_exec(b));
        chk_r11();
        rom_data = ~b;
        if (!b[7] && !b[6] && b[5:3] == 3'd7) begin
            for (int k = 0; k < 4; k++) begin
                rom_data = 8'(k * 37 + 5);
                @(posedge clk); @(negedge clk);
                chk("R9", act_vec(), '0);
                chk_ir("R9", b);
            end
        end else if (!b[7] && !b[6] && (b[5:3] == 3'd0 || (b[5:3] >= 3'd2 && b[5:3] <= 3'd4))) begin
            @(posedge clk); @(negedge clk);
            {fn, fc, fz} = ~f;
            #1;
            if (b[5:3] == 3'd0) begin
                chk("R5", act_vec(), pk(1'b0, 4'd0, 4'd8, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0));
            end else begin
                tk = (b[5:3] == 3'd2) ? f[0] : (b[5:3] == 3'd3) ? f[1] : f[2];
                chk("R8", act_vec(), tk ? pk(1'b0, 4'd0, 4'd6, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0)
                                        : pk(1'b0, 4'd0, 4'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
            end
            chk_ir("R2", b);
            chk_r11();
            @(posedge clk); @(negedge clk);
        end else begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    initial begin
        do_reset();
        for (int i = 0; i < 256; i++) begin
            logic [7:0] b;
            b = 8'(i);
            if (!b[7] && !b[6] && b[5:3] >= 3'd2 && b[5:3] <= 3'd4) begin
                for (int f = 0; f < 8; f++) run(b, 3'(f)); // R7 all flag patterns
            end else begin
                run(b, 3'd0);
            end
            if (!b[7] && !b[6] && b[5:3] == 3'd7) do_reset();
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule